// File: doc/BRIEF.md
# Over-Current Pulse-Skip Sequencer

This block sits between the current-limit comparator of a synchronous buck converter and its high-side gate control. At every switching-cycle start strobe it looks at a current-limit flag that is already synchronous to its clock. When the flag is seen while the sequencer is idle, the high-side enable is withheld and a run of skipped pulses begins. After the skip run, switching resumes for a retry window. A second detection inside that window latches an over-current fault that keeps the converter off. A window that passes with no detection returns the sequencer to idle by itself.

The latched fault stays set until the converter is disabled by the enable input or the supply-good input. Dropping either input also parks the sequencer in idle, clears its cycle counter and holds the high-side inhibit on. The current state and the cycle count are brought out so that neighbouring logic can observe them. The fault output is meant to pull the converter's power-good indication low. Sensing, limit threshold setting and gate driving sit outside this block.

Top module: `ocp_skip_seq`

## Requirements
- R1: After reset, or while `enable` is low, `hs_inhibit` is 1, `oc_fault` is 0, `seq_state` is 0 (idle) and `cyc_count` is 0.
- R2: In idle with `enable` and `supply_ok` both high, `hs_inhibit` is 0. A high `ilim_flag` has no effect unless `cyc_start` is high in the same clock, and a strobe with the flag low leaves the block idle.
- R3: A strobe with the flag high while idle moves `seq_state` to 1 (skip) and raises `hs_inhibit` one clock later, with `cyc_count` at 0.
- R4: In skip state, `hs_inhibit` stays 1 through the next SKIP_CYCLES strobes (8 by default), and the flag is ignored at those strobes.
- R5: At strobe SKIP_CYCLES+1 with the flag low, `seq_state` becomes 2 (watch) and `hs_inhibit` drops to 0, so the high side switches normally during the retry window.
- R6: A flag seen at any strobe from SKIP_CYCLES+1 through SKIP_CYCLES+WIN_CYCLES (9 to 16 by default) sets `oc_fault`, moves `seq_state` to 3 (fault), sets `hs_inhibit` and clears `cyc_count`.
- R7: If strobe SKIP_CYCLES+WIN_CYCLES passes with the flag low, the block returns to idle with `cyc_count` 0 and `hs_inhibit` 0.
- R8: A latched fault persists through any strobe and flag pattern while `enable` and `supply_ok` stay high. It clears, and the block returns to idle, one clock after `enable` goes low.
- R9: A low `supply_ok` has the same effect as a low `enable`: the inhibit is forced on at once, and the fault, the count and the state are cleared one clock later.
- R10: In skip and watch states, `cyc_count` equals the number of strobes since the detection. The count is CNT_W bits wide (5 by default) and saturates instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| ilim_flag | input | 1 | Synchronous current-limit comparator output |
| enable | input | 1 | Converter enable; low clears a latched fault |
| supply_ok | input | 1 | Supply-good; low clears a latched fault |
| hs_inhibit | output | 1 | 1 blocks the high-side gate enable |
| oc_fault | output | 1 | Latched over-current fault; drives power-good low |
| seq_state | output | 2 | 0 idle, 1 skip, 2 watch, 3 fault |
| cyc_count | output | CNT_W | Strobes counted since the detection |

## Verification
The bench builds the sequencer with its default values: eight skipped cycles, an eight-cycle retry window and a 5-bit counter. With these values the boundary strobes 8, 9 and 16 can be driven directly, along with the first strobe after a window that ends with no detection. The bench also places flags between strobes and inside the skip run to confirm that they are ignored. It checks that both the enable input and the supply-good input clear a latched fault.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SKIP  = 2'd1,
    ST_WATCH = 2'd2,
    ST_FAULT = 2'd3
  } ocp_state_t;
endpackage

// File: rtl/ocp_cycle_counter.sv
module ocp_cycle_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        count <= '0;
    else if (clr)                      count <= '0;
    else if (inc && count != CNT_MAX)  count <= count + 1'b1;
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && count == CNT_MAX) |=> (count == CNT_MAX)); // R10
endmodule

// File: rtl/ocp_fault_latch.sv
module ocp_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic fault
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fault <= 1'b0;
    else if (clr)  fault <= 1'b0;
    else if (set)  fault <= 1'b1;
  end

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !clr) |=> fault); // R8
endmodule

// File: rtl/ocp_seq_fsm.sv
module ocp_seq_fsm
  import ocp_pkg::*;
#(
  parameter int SKIP_CYCLES = 8,
  parameter int WIN_CYCLES  = 8,
  parameter int CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             cyc_start,
  input  logic             ilim,
  input  logic [CNT_W-1:0] count,
  output ocp_state_t       state,
  output logic             cnt_inc,
  output logic             cnt_clr,
  output logic             fault_set
);
  localparam logic [CNT_W-1:0] LAST_SKIP  = CNT_W'(SKIP_CYCLES);
  localparam logic [CNT_W-1:0] LAST_WIN   = CNT_W'(SKIP_CYCLES + WIN_CYCLES);
  localparam logic [CNT_W-1:0] WIN_BEFORE = CNT_W'(SKIP_CYCLES + WIN_CYCLES - 1);

  ocp_state_t state_n;

  always_comb begin
    state_n   = state;
    cnt_inc   = 1'b0;
    cnt_clr   = 1'b0;
    fault_set = 1'b0;
    if (!active) begin
      state_n = ST_IDLE;
      cnt_clr = 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt_clr = 1'b1;
          if (cyc_start && ilim) state_n = ST_SKIP;
        end
        ST_SKIP: begin
          if (cyc_start) begin
            if (count == LAST_SKIP) begin
              if (ilim) begin
                state_n   = ST_FAULT;
                cnt_clr   = 1'b1;
                fault_set = 1'b1;
              end else begin
                state_n = ST_WATCH;
                cnt_inc = 1'b1;
              end
            end else begin
              cnt_inc = 1'b1;
            end
          end
        end
        ST_WATCH: begin
          if (cyc_start) begin
            if (ilim) begin
              state_n   = ST_FAULT;
              cnt_clr   = 1'b1;
              fault_set = 1'b1;
            end else if (count == WIN_BEFORE) begin
              state_n = ST_IDLE;
              cnt_clr = 1'b1;
            end else begin
              cnt_inc = 1'b1;
            end
          end
        end
        default: cnt_clr = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_n;
  end

  AST_SKIP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (active && state == ST_IDLE && cyc_start && ilim) |=> (state == ST_SKIP && count == '0)); // R3

  AST_WATCH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WATCH) |-> (count > LAST_SKIP && count < LAST_WIN)); // R5

  AST_SKIP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> (count <= LAST_SKIP)); // R4
endmodule

// File: rtl/ocp_skip_seq.sv
module ocp_skip_seq
  import ocp_pkg::*;
#(
  parameter int SKIP_CYCLES = 8,
  parameter int WIN_CYCLES  = 8,
  parameter int CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             ilim_flag,
  input  logic             enable,
  input  logic             supply_ok,
  output logic             hs_inhibit,
  output logic             oc_fault,
  output logic [1:0]       seq_state,
  output logic [CNT_W-1:0] cyc_count
);
  logic       active;
  logic       cnt_inc, cnt_clr, fault_set;
  ocp_state_t state;

  assign active = enable && supply_ok;

  ocp_seq_fsm #(
    .SKIP_CYCLES(SKIP_CYCLES),
    .WIN_CYCLES (WIN_CYCLES),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .cyc_start(cyc_start),
    .ilim     (ilim_flag),
    .count    (cyc_count),
    .state    (state),
    .cnt_inc  (cnt_inc),
    .cnt_clr  (cnt_clr),
    .fault_set(fault_set)
  );

  ocp_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clr),
    .inc  (cnt_inc),
    .count(cyc_count)
  );

  ocp_fault_latch u_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (fault_set),
    .clr  (!active),
    .fault(oc_fault)
  );

  assign seq_state  = state;
  assign hs_inhibit = !active || oc_fault || state == ST_SKIP || state == ST_FAULT;

  AST_FAULT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    oc_fault == (state == ST_FAULT)); // R6

  AST_INHIBIT_IN_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> hs_inhibit); // R4

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (state == ST_IDLE && cyc_count == '0 && !oc_fault)); // R8

  AST_WATCH_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WATCH && active) |-> !hs_inhibit); // R5
endmodule

// File: tb/ocp_skip_seq_test.sv
module ocp_skip_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_start = 1'b0;
  logic       ilim_flag = 1'b0;
  logic       enable = 1'b0;
  logic       supply_ok = 1'b1;
  logic       hs_inhibit, oc_fault;
  logic [1:0] seq_state;
  logic [4:0] cyc_count;
  int         n_checks = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  ocp_skip_seq uut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .ilim_flag(ilim_flag),
    .enable(enable), .supply_ok(supply_ok), .hs_inhibit(hs_inhibit),
    .oc_fault(oc_fault), .seq_state(seq_state), .cyc_count(cyc_count)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_all(input string req, input int inh, input int flt,
                            input int st, input int cnt);
    check({req, " inhibit"}, hs_inhibit, inh);
    check({req, " fault"},   oc_fault,   flt);
    check({req, " state"},   seq_state,  st);
    check({req, " count"},   cyc_count,  cnt);
  endtask

  task automatic strobe(input logic flag);
    @(negedge clk);
    cyc_start = 1'b1;
    ilim_flag = flag;
    @(negedge clk);
    cyc_start = 1'b0;
    ilim_flag = 1'b0;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic detect_and_skip(input logic flag_in_skip);
    strobe(1'b1);
    expect_all("R3 entry", 1, 0, 1, 0);
    for (int k = 1; k <= 8; k++) begin
      gap(2);
      strobe(flag_in_skip);
      expect_all("R4 skip", 1, 0, 1, k);
      check("R10 count", cyc_count, k);
    end
  endtask

  task automatic t_reset;
    gap(1);
    expect_all("R1 reset", 1, 0, 0, 0);
    rst_n = 1'b1;
    gap(2);
    expect_all("R1 disabled", 1, 0, 0, 0);
  endtask

  task automatic t_idle;
    enable = 1'b1;
    gap(1);
    expect_all("R2 idle", 0, 0, 0, 0);
    ilim_flag = 1'b1;
    gap(3);
    ilim_flag = 1'b0;
    expect_all("R2 flag without strobe", 0, 0, 0, 0);
    strobe(1'b0);
    expect_all("R2 clean strobe", 0, 0, 0, 0);
  endtask

  task automatic t_clean_window;
    detect_and_skip(1'b1);
    gap(1);
    strobe(1'b0);
    expect_all("R5 window open", 0, 0, 2, 9);
    for (int k = 10; k <= 15; k++) begin
      strobe(1'b0);
      expect_all("R5 window", 0, 0, 2, k);
    end
    strobe(1'b0);
    expect_all("R7 window closes", 0, 0, 0, 0);
    strobe(1'b0);
    expect_all("R7 after window", 0, 0, 0, 0);
  endtask

  task automatic t_fault_at_9;
    detect_and_skip(1'b0);
    strobe(1'b1);
    expect_all("R6 fault at 9", 1, 1, 3, 0);
    strobe(1'b0);
    strobe(1'b1);
    gap(4);
    expect_all("R8 fault holds", 1, 1, 3, 0);
    enable = 1'b0;
    #0.1;
    check("R8 inhibit on disable", hs_inhibit, 1);
    gap(1);
    expect_all("R8 cleared", 1, 0, 0, 0);
    enable = 1'b1;
    gap(1);
    expect_all("R8 re-enabled", 0, 0, 0, 0);
  endtask

  task automatic t_fault_at_16;
    detect_and_skip(1'b0);
    for (int k = 9; k <= 15; k++) strobe(1'b0);
    expect_all("R5 before last", 0, 0, 2, 15);
    strobe(1'b1);
    expect_all("R6 fault at 16", 1, 1, 3, 0);
    supply_ok = 1'b0;
    gap(1);
    expect_all("R9 supply drop", 1, 0, 0, 0);
    supply_ok = 1'b1;
    gap(1);
    expect_all("R9 restored", 0, 0, 0, 0);
  endtask

  task automatic t_supply_during_skip;
    strobe(1'b1);
    expect_all("R3 second entry", 1, 0, 1, 0);
    strobe(1'b0);
    supply_ok = 1'b0;
    gap(1);
    expect_all("R9 abort skip", 1, 0, 0, 0);
    supply_ok = 1'b1;
    gap(1);
    check("R9 idle again", hs_inhibit, 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_clean_window();
    t_fault_at_9();
    t_fault_at_16();
    t_supply_during_skip();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule